// File: doc/BRIEF.md
# Rescheduled Triangular Spread Modulator

This block drives the frequency-spreading side of an all-digital clock generator. One modulation cycle is cut into N sub-sections, each held for a fixed number of system clocks. Every sub-section stands for one offset level of the oscillator control code, in units of a spreading step S, around a stored center code. On each change of sub-section the block emits the code change as a direction bit and a magnitude, and an external adder/subtractor applies it to the oscillator code. That adder, the loop filter that holds the center, and the oscillator itself sit outside this block.

A plain triangle would allow phase correction only once per modulation cycle. Here the sub-sections are grouped by four, and each group's four offsets add up to zero. The code therefore comes back to zero average drift at the end of every group, and a one-clock strobe tells the loop filter that it may apply a phase correction there. Within a group, the sub-sections are visited in an interleaved order. This keeps the largest jump between neighbouring sub-sections to N/4+1 steps, where a straight divided ordering would need N/2-1.

Top module: `tri_spread_sched`

## Requirements
- R1: The sub-section count is N = 4 << cnt_sel for cnt_sel 0 to 4 (4, 8, 16, 32, 64). Values 5 to 7 also select 64. After sub-section N-1 the sequence wraps to sub-section 0.
- R2: The step is S = 1 << step_sel. On a change, step_mag = |new offset - old offset| * S. dir_dn is 1 when the offset decreases (subtract) and 0 when it increases. When step_mag is 0, dir_dn is 0.
- R3: Let A = N/4, g = i >> 2 and p = i & 3 for sub-section i. The offset of sub-section i is g, A-g, -g or g-A for p = 0, 1, 2, 3 respectively. Sub-section 0 is offset 0, which is the center.
- R4: Over a full cycle, the peak |offset change| between adjacent sub-sections (wrap included) is 1, 3, 5, 9 and 17 steps for N = 4, 8, 16, 32 and 64.
- R5: Each sub-section lasts DWELL clocks. With spread_en high from rising edge 1 onward, transitions happen on edges DWELL, 2*DWELL, and so on. Each transition's outputs are present for exactly the one clock that follows that edge. Outside a transition, step_mag is 0.
- R6: track_win pulses for one clock together with the transition that leaves a sub-section with i & 3 = 3. This happens every 4*DWELL clocks, N/4 times per modulation cycle.
- R7: Over one modulation cycle, the applied steps sum to zero. The clock-weighted sum of the offset is also zero.
- R8: While spread_en is low, the outputs are zero from the next clock on. The sequence returns to sub-section 0 at the center. After re-enable, the first transition moves from offset 0 to the offset of sub-section 1.
- R9: While rst_n is low, dir_dn, step_mag and track_win are 0 and the sequence sits at sub-section 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-derived system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spread_en | input | 1 | Spreading enable |
| cnt_sel | input | 3 | Sub-section count select |
| step_sel | input | 3 | Spreading step select |
| dir_dn | output | 1 | 1 = subtract step_mag, 0 = add |
| step_mag | output | 16 | Code change for this clock |
| track_win | output | 1 | Phase-correction window strobe |

## Verification
The hardest situation to reach is a modulation cycle cut short. The stimulus disables spreading mid-group, after several transitions have moved the offset away from center, and then re-enables it. The first transition after re-enable must be referenced to the center and not to the stale offset. The count-64 sequences take 256 clocks per cycle to reach their peak jumps and the wrap. The bench walks every select value once over a complete cycle, and it accumulates both the applied code and its time integral.

// File: rtl/tri_spread_sched.sv
module tri_spread_sched #(
  parameter int DWELL  = 4,
  parameter int STEP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spread_en,
  input  logic [2:0]        cnt_sel,
  input  logic [2:0]        step_sel,
  output logic              dir_dn,
  output logic [STEP_W-1:0] step_mag,
  output logic              track_win
);
  localparam int DW_W  = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam int IDX_W = 6;
  localparam int LVL_W = 8;

  logic [IDX_W-1:0]        idx_q, idx_nx;
  logic [DW_W-1:0]         dwell_q;
  logic signed [LVL_W-1:0] lvl_q, lvl_nx, delta;
  logic [LVL_W-1:0]        absd;
  logic [6:0]              cnt_n;
  logic [4:0]              amp;
  logic                    sub_end;

  function automatic logic signed [LVL_W-1:0] level_at(input logic [IDX_W-1:0] i,
                                                        input logic [4:0] a);
    logic signed [LVL_W-1:0] g, av;
    g  = $signed({4'b0, i[5:2]});
    av = $signed({3'b0, a});
    case (i[1:0])
      2'd0:    level_at = g;
      2'd1:    level_at = av - g;
      2'd2:    level_at = -g;
      default: level_at = g - av;
    endcase
  endfunction

  assign cnt_n   = (cnt_sel > 3'd4) ? 7'd64 : 7'(7'd4 << cnt_sel);
  assign amp     = cnt_n[6:2];
  assign sub_end = dwell_q == DW_W'(DWELL - 1);
  assign idx_nx  = ({1'b0, idx_q} >= cnt_n - 7'd1) ? '0 : idx_q + 1'b1;
  assign lvl_nx  = level_at(idx_nx, amp);
  assign delta   = lvl_nx - lvl_q;
  assign absd    = delta[LVL_W-1] ? LVL_W'(-delta) : LVL_W'(delta);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= '0;
      dwell_q   <= '0;
      lvl_q     <= '0;
      dir_dn    <= 1'b0;
      step_mag  <= '0;
      track_win <= 1'b0;
    end else if (!spread_en) begin
      idx_q     <= '0;
      dwell_q   <= '0;
      lvl_q     <= '0;
      dir_dn    <= 1'b0;
      step_mag  <= '0;
      track_win <= 1'b0;
    end else if (sub_end) begin
      dwell_q   <= '0;
      idx_q     <= idx_nx;
      lvl_q     <= lvl_nx;
      dir_dn    <= delta[LVL_W-1];
      step_mag  <= STEP_W'(absd) << step_sel;
      track_win <= idx_q[1:0] == 2'b11;
    end else begin
      dwell_q   <= dwell_q + 1'b1;
      dir_dn    <= 1'b0;
      step_mag  <= '0;
      track_win <= 1'b0;
    end
  end
endmodule

// File: rtl/tri_spread_sched_chk.sv
module tri_spread_sched_chk #(
  parameter int DWELL  = 4,
  parameter int STEP_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spread_en,
  input logic [2:0]        cnt_sel,
  input logic [2:0]        step_sel,
  input logic              dir_dn,
  input logic [STEP_W-1:0] step_mag,
  input logic              track_win
);
  logic [2:0]        cs_q, ss_q;
  logic              stab_q, seen_q;
  logic [STEP_W-1:0] bound_q;
  int unsigned       since_q;
  logic [4:0]        peak;

  assign peak = (cnt_sel == 3'd0) ? 5'd1 :
                (cnt_sel == 3'd1) ? 5'd3 :
                (cnt_sel == 3'd2) ? 5'd5 :
                (cnt_sel == 3'd3) ? 5'd9 : 5'd17;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= '0;
      ss_q    <= '0;
      stab_q  <= 1'b1;
      seen_q  <= 1'b0;
      bound_q <= '0;
      since_q <= 0;
    end else begin
      cs_q    <= cnt_sel;
      ss_q    <= step_sel;
      bound_q <= STEP_W'(peak) << step_sel;
      stab_q  <= !spread_en || (stab_q && cnt_sel == cs_q && step_sel == ss_q);
      since_q <= track_win ? 0 : since_q + 1;
      if (!spread_en || !stab_q) seen_q <= 1'b0;
      else if (track_win)        seen_q <= 1'b1;
    end
  end

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !spread_en |=> (step_mag == '0 && !dir_dn && !track_win));

  a_r4_jump_bound: assert property (@(posedge clk) disable iff (!rst_n)
    stab_q |-> step_mag <= bound_q);

  a_r2_no_neg_zero: assert property (@(posedge clk) disable iff (!rst_n)
    step_mag == '0 |-> !dir_dn);

  a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    track_win |=> !track_win);

  a_r6_strobe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (track_win && seen_q && stab_q && spread_en) |-> since_q == 4 * DWELL - 1);
endmodule

bind tri_spread_sched tri_spread_sched_chk #(.DWELL(DWELL), .STEP_W(STEP_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .spread_en(spread_en), .cnt_sel(cnt_sel),
  .step_sel(step_sel), .dir_dn(dir_dn), .step_mag(step_mag), .track_win(track_win)
);

// File: tb/tri_spread_sched_tb_top.sv
module tri_spread_sched_tb_top;
  localparam int D = 4;
  localparam int NV = 6;
  localparam int V_CS   [NV] = '{0, 1, 2, 3, 4, 7};
  localparam int V_SS   [NV] = '{0, 3, 1, 2, 0, 7};
  localparam int V_N    [NV] = '{4, 8, 16, 32, 64, 64};
  localparam int V_PEAK [NV] = '{1, 3, 5, 9, 17, 17};

  logic clk = 0, rst_n = 0, spread_en = 0;
  logic [2:0] cnt_sel = 0, step_sel = 0;
  logic dir_dn, track_win;
  logic [15:0] step_mag;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tri_spread_sched #(.DWELL(D), .STEP_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .spread_en(spread_en), .cnt_sel(cnt_sel),
    .step_sel(step_sel), .dir_dn(dir_dn), .step_mag(step_mag), .track_win(track_win));

  function automatic int lvl(int i, int n);
    int a = n / 4, g = i / 4;
    case (i % 4)
      0: return g;
      1: return a - g;
      2: return -g;
      default: return g - a;
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sval();
    return dir_dn ? -int'(step_mag) : int'(step_mag);
  endfunction

  task automatic run_vec(int v);
    int n = V_N[v], s = 1 << V_SS[v];
    int off = 0, area = 0, peak = 0, seq_bad = 0, trk_bad = 0, trk_n = 0;
    @(negedge clk);
    spread_en = 0;
    cnt_sel = 3'(V_CS[v]);
    step_sel = 3'(V_SS[v]);
    @(negedge clk);
    spread_en = 1;
    for (int k = 1; k <= n * D; k++) begin
      int exp_d;
      @(negedge clk);
      off += sval();
      area += off;
      if (int'(step_mag) > peak) peak = int'(step_mag);
      exp_d = (k % D == 0) ? (lvl((k / D) % n, n) - lvl(k / D - 1, n)) * s : 0;
      if (sval() != exp_d || (step_mag == 0 && dir_dn)) seq_bad++;
      if (track_win != (k % (4 * D) == 0)) trk_bad++;
      if (track_win) trk_n++;
    end
    chk("R1 R3 R5", $sformatf("vec%0d step sequence mismatches", v), seq_bad, 0);
    chk("R2 R4", $sformatf("vec%0d peak step", v), peak, V_PEAK[v] * s);
    chk("R6", $sformatf("vec%0d strobe timing mismatches", v), trk_bad, 0);
    chk("R6", $sformatf("vec%0d strobes per cycle", v), trk_n, n / 4);
    chk("R7", $sformatf("vec%0d net offset", v), off, 0);
    chk("R7", $sformatf("vec%0d weighted offset", v), area, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int off;
    repeat (3) @(negedge clk);
    chk("R9", "reset step_mag", int'(step_mag), 0);
    chk("R9", "reset dir/strobe", int'({dir_dn, track_win}), 0);
    rst_n = 1;
    repeat (6) @(negedge clk);
    chk("R8", "idle step_mag", int'(step_mag), 0);

    for (int v = 0; v < NV; v++) run_vec(v);

    // R8: disable mid-group, then restart from center
    @(negedge clk);
    spread_en = 0; cnt_sel = 3'd2; step_sel = 3'd0;
    @(negedge clk);
    spread_en = 1;
    off = 0;
    for (int k = 1; k <= 3 * D + 2; k++) begin
      @(negedge clk);
      off += sval();
    end
    chk("R8", "offset before disable", off, lvl(3, 16));
    spread_en = 0;
    @(negedge clk);
    chk("R8", "disabled step_mag", int'(step_mag), 0);
    chk("R8", "disabled strobe", int'(track_win), 0);
    repeat (4) @(negedge clk);
    spread_en = 1;
    for (int k = 1; k < D; k++) begin
      @(negedge clk);
      chk("R5", "no step inside first dwell", int'(step_mag), 0);
    end
    @(negedge clk);
    chk("R8", "first step after re-enable", sval(), lvl(1, 16) - lvl(0, 16));

    // R9: reset in mid-run
    repeat (2 * D) @(negedge clk);
    rst_n = 0;
    #1;
    chk("R9", "mid-run reset step_mag", int'(step_mag), 0);
    @(negedge clk);
    rst_n = 1;
    repeat (D - 1) @(negedge clk);
    chk("R9", "after reset still in dwell", int'(step_mag), 0);
    @(negedge clk);
    chk("R9", "restart at sub-section 0", sval(), lvl(1, 16));

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule